// File: doc/BRIEF.md
# Field-Selected Register File with Branch and Shift Logic

This block holds the thirty-two 32-bit general registers of a bus-based RISC core. The control sequencer never supplies register numbers. Instead it raises one of three grant lines, and each grant picks a register field out of the current instruction word. The same selection serves both reading and writing. A read can go onto the shared bus in two ways. The plain path returns the register contents. The base-address path returns zero when the selected index is 0, which lets displacement addressing treat register 0 as "no base".

A second read port is not affected by the grants. It always returns the register named by the rc field. Two small units take their input from this port. The first reduces the instruction's 3-bit condition code to a single branch flag, so the sequencer only has to look at one bit. The second produces the 5-bit shift amount. It uses the immediate count from the instruction, or the low bits of the rc register when that immediate is zero.

A third unit drives the two immediate constants of the instruction onto the bus in sign-extended form. The sequencer raises at most one bus source per cycle. The block flags which cycles it is driving the bus. All control pins are plain levels. The block has no streaming data path, so it has no valid/ready handshake and no back-pressure.

Top module: `fieldsel_regfile`

## Requirements
- R1: After an active-low reset, every register reads as zero.
- R2: On a rising clock edge where `wr_en_i` is high, the bus value `bus_i` is written into the register chosen by the grants. The fields are ra = IR[26:22], rb = IR[21:17] and rc = IR[16:12]. When several grants are high, ra wins over rb, and rb wins over rc. With no grant high, nothing is written.
- R3: When `rd_en_i` is high and a grant is high, `bus_o` equals the selected register and `bus_oe_o` is high. With no grant, `bus_o` is zero.
- R4: When `base_rd_i` is high, `bus_o` is zero if the selected index is 0. Otherwise it equals the selected register.
- R5: `rc_val_o` always equals the register named by IR[16:12], whatever the grants are.
- R6: `cond_o` depends on the condition code in IR[2:0]. Code 0 gives 0 and code 1 gives 1. Code 2 gives 1 when the rc register is zero, and code 3 gives 1 when it is nonzero. Code 4 gives 1 when bit 31 of the rc register is 0, and code 5 gives 1 when that bit is 1. Codes 6 and 7 give 0.
- R7: `shamt_o` equals IR[4:0] when that field is nonzero. Otherwise it equals bits 4:0 of the rc register. The count is unsigned.
- R8: `c1_drv_i` drives IR[21:0] onto the bus, sign-extended from bit 21. `c2_drv_i` drives IR[16:0], sign-extended from bit 16.
- R9: `bus_oe_o` is high exactly when one of the four drive controls is high. When none is high, `bus_o` is zero.
- R10: Register 0 is an ordinary register. It stores values and returns them through the plain read path and through the rc port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears all registers |
| ir_i | input | 32 | Current instruction word |
| sel_a_i | input | 1 | Grant: select the ra field |
| sel_b_i | input | 1 | Grant: select the rb field |
| sel_c_i | input | 1 | Grant: select the rc field |
| wr_en_i | input | 1 | Write the bus value into the selected register |
| rd_en_i | input | 1 | Drive the selected register onto the bus |
| base_rd_i | input | 1 | Base-address read, zero when index 0 |
| c1_drv_i | input | 1 | Drive sign-extended 22-bit constant |
| c2_drv_i | input | 1 | Drive sign-extended 17-bit constant |
| bus_i | input | 32 | Value on the shared bus, write data |
| bus_o | output | 32 | Value this block drives to the bus |
| bus_oe_o | output | 1 | High when this block drives the bus |
| rc_val_o | output | 32 | Register named by the rc field |
| cond_o | output | 1 | Branch condition flag |
| shamt_o | output | 5 | Shift amount |

## Verification
Every output except the register contents is combinational. A read, a constant, the branch flag or the shift amount is therefore due in the same cycle as the stimulus that causes it. A write becomes visible in the cycle after its clock edge. The bench applies each stimulus just after a falling edge and samples one nanosecond later, which is before the rising edge that performs any write. It then checks the written value with a later read, counting one edge of latency.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int DATA_W  = 32;
  localparam int NREG    = 32;
  localparam int IDX_W   = $clog2(NREG);
  localparam int IR_W    = 32;
  // instruction field positions (fixed by the decode contract)
  localparam int RA_LSB  = 22;
  localparam int RB_LSB  = 17;
  localparam int RC_LSB  = 12;
  localparam int C1_W    = 22;
  localparam int C2_W    = 17;
  localparam int CC_W    = 3;
  localparam int SH_W    = 5;

  typedef enum logic [CC_W-1:0] {
    CC_NEVER  = 3'd0,
    CC_ALWAYS = 3'd1,
    CC_ZERO   = 3'd2,
    CC_NZERO  = 3'd3,
    CC_PLUS   = 3'd4,
    CC_MINUS  = 3'd5
  } cc_e;
endpackage

// File: rtl/fsr_field_sel.sv
module fsr_field_sel #(
  parameter int IDX_W = fsr_pkg::IDX_W
) (
  input  logic [IDX_W-1:0] fa_i,
  input  logic [IDX_W-1:0] fb_i,
  input  logic [IDX_W-1:0] fc_i,
  input  logic             sel_a_i,
  input  logic             sel_b_i,
  input  logic             sel_c_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             hit_o
);
  always_comb begin
    idx_o = '0;
    if (sel_a_i)      idx_o = fa_i;
    else if (sel_b_i) idx_o = fb_i;
    else if (sel_c_i) idx_o = fc_i;
  end
  assign hit_o = sel_a_i | sel_b_i | sel_c_i;
endmodule

// File: rtl/fsr_regs.sv
module fsr_regs #(
  parameter int DATA_W = fsr_pkg::DATA_W,
  parameter int NREG   = fsr_pkg::NREG,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [IDX_W-1:0]  cidx_i,
  output logic [DATA_W-1:0] cdata_o
);
  logic [DATA_W-1:0] q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              q[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g))    q[g] <= wdata_i;
    end
  end

  assign rdata_o = q[ridx_i];
  assign cdata_o = q[cidx_i];
endmodule

// File: rtl/fsr_branch_eval.sv
module fsr_branch_eval #(
  parameter int DATA_W = fsr_pkg::DATA_W
) (
  input  logic [fsr_pkg::CC_W-1:0] code_i,
  input  logic [DATA_W-1:0]        rc_i,
  output logic                     con_o
);
  import fsr_pkg::*;
  always_comb begin
    case (code_i)
      CC_NEVER:  con_o = 1'b0;
      CC_ALWAYS: con_o = 1'b1;
      CC_ZERO:   con_o = (rc_i == '0);
      CC_NZERO:  con_o = (rc_i != '0);
      CC_PLUS:   con_o = ~rc_i[DATA_W-1];
      CC_MINUS:  con_o = rc_i[DATA_W-1];
      default:   con_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fsr_shift_count.sv
module fsr_shift_count #(
  parameter int SH_W = fsr_pkg::SH_W
) (
  input  logic [SH_W-1:0] imm_i,
  input  logic [SH_W-1:0] rc_lo_i,
  output logic [SH_W-1:0] n_o
);
  assign n_o = (imm_i != '0) ? imm_i : rc_lo_i;
endmodule

// File: rtl/fsr_const_drv.sv
module fsr_const_drv #(
  parameter int DATA_W = fsr_pkg::DATA_W,
  parameter int C1_W   = fsr_pkg::C1_W,
  parameter int C2_W   = fsr_pkg::C2_W
) (
  input  logic [C1_W-1:0]   c1_field_i,
  output logic [DATA_W-1:0] c1_o,
  output logic [DATA_W-1:0] c2_o
);
  localparam int EXT1 = DATA_W - C1_W;
  localparam int EXT2 = DATA_W - C2_W;
  assign c1_o = {{EXT1{c1_field_i[C1_W-1]}}, c1_field_i};
  assign c2_o = {{EXT2{c1_field_i[C2_W-1]}}, c1_field_i[C2_W-1:0]};
endmodule

// File: rtl/fieldsel_regfile.sv
module fieldsel_regfile
  import fsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IR_W-1:0]   ir_i,
  input  logic              sel_a_i,
  input  logic              sel_b_i,
  input  logic              sel_c_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              base_rd_i,
  input  logic              c1_drv_i,
  input  logic              c2_drv_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic [DATA_W-1:0] rc_val_o,
  output logic              cond_o,
  output logic [SH_W-1:0]   shamt_o
);
  logic [IDX_W-1:0]  f_ra, f_rb, f_rc, sel_idx;
  logic              sel_hit;
  logic [DATA_W-1:0] rd_data, c1_val, c2_val;
  logic              unused_opcode;

  assign f_ra = ir_i[RA_LSB +: IDX_W];
  assign f_rb = ir_i[RB_LSB +: IDX_W];
  assign f_rc = ir_i[RC_LSB +: IDX_W];
  assign unused_opcode = ^ir_i[IR_W-1:RA_LSB+IDX_W];

  fsr_field_sel #(.IDX_W(IDX_W)) u_sel (
    .fa_i(f_ra), .fb_i(f_rb), .fc_i(f_rc),
    .sel_a_i(sel_a_i), .sel_b_i(sel_b_i), .sel_c_i(sel_c_i),
    .idx_o(sel_idx), .hit_o(sel_hit)
  );

  fsr_regs #(.DATA_W(DATA_W), .NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we_i(wr_en_i & sel_hit), .widx_i(sel_idx), .wdata_i(bus_i),
    .ridx_i(sel_idx), .rdata_o(rd_data),
    .cidx_i(f_rc), .cdata_o(rc_val_o)
  );

  fsr_branch_eval #(.DATA_W(DATA_W)) u_br (
    .code_i(ir_i[CC_W-1:0]), .rc_i(rc_val_o), .con_o(cond_o)
  );

  fsr_shift_count #(.SH_W(SH_W)) u_sh (
    .imm_i(ir_i[SH_W-1:0]), .rc_lo_i(rc_val_o[SH_W-1:0]), .n_o(shamt_o)
  );

  fsr_const_drv #(.DATA_W(DATA_W), .C1_W(C1_W), .C2_W(C2_W)) u_const (
    .c1_field_i(ir_i[C1_W-1:0]), .c1_o(c1_val), .c2_o(c2_val)
  );

  always_comb begin
    bus_o = '0;
    if (rd_en_i) begin
      if (sel_hit) bus_o = rd_data;
    end else if (base_rd_i) begin
      if (sel_hit && sel_idx != '0) bus_o = rd_data;
    end else if (c1_drv_i) begin
      bus_o = c1_val;
    end else if (c2_drv_i) begin
      bus_o = c2_val;
    end
  end

  assign bus_oe_o = rd_en_i | base_rd_i | c1_drv_i | c2_drv_i;
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [26:0] ir_lo,
  input logic        sel_a,
  input logic        sel_b,
  input logic        sel_c,
  input logic        wr_en,
  input logic        rd_en,
  input logic        base_rd,
  input logic        c1_drv,
  input logic        c2_drv,
  input logic [31:0] bus_in,
  input logic [31:0] bus_out,
  input logic        bus_oe,
  input logic [31:0] rc_val,
  input logic        cond,
  input logic [4:0]  shamt
);
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rd_en, base_rd, c1_drv, c2_drv}) <= 1); // R9

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> bus_out == 32'h0); // R9

  AST_BASE_R0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (base_rd && sel_a && ir_lo[26:22] == 5'd0) |-> bus_out == 32'h0); // R4

  AST_RC_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_c && !sel_a && !sel_b)
      |=> (!$stable(ir_lo) || rc_val == $past(bus_in))); // R2

  AST_CON_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_lo[2:0] == 3'd0 || ir_lo[2:1] == 2'b11) |-> !cond); // R6

  AST_SHIFT_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_lo[4:0] != 5'd0) |-> shamt == ir_lo[4:0]); // R7

  AST_C2_SIGNEXT: assert property (@(posedge clk) disable iff (!rst_n)
    c2_drv |-> bus_out[31:16] == {16{ir_lo[16]}}); // R8
endmodule

bind fieldsel_regfile fsr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ir_lo(ir_i[26:0]),
  .sel_a(sel_a_i), .sel_b(sel_b_i), .sel_c(sel_c_i),
  .wr_en(wr_en_i), .rd_en(rd_en_i), .base_rd(base_rd_i),
  .c1_drv(c1_drv_i), .c2_drv(c2_drv_i), .bus_in(bus_i),
  .bus_out(bus_o), .bus_oe(bus_oe_o), .rc_val(rc_val_o),
  .cond(cond_o), .shamt(shamt_o)
);

// File: tb/fieldsel_regfile_tb.sv
module fieldsel_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ir = '0;
  logic        sa = 0, sb = 0, sc = 0, we = 0, rd = 0, ba = 0, k1 = 0, k2 = 0;
  logic [31:0] bin = '0;
  logic [31:0] bout, rcv;
  logic        oe, con;
  logic [4:0]  n;

  always #2 clk = ~clk;  // 250 MHz

  fieldsel_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .ir_i(ir),
    .sel_a_i(sa), .sel_b_i(sb), .sel_c_i(sc),
    .wr_en_i(we), .rd_en_i(rd), .base_rd_i(ba),
    .c1_drv_i(k1), .c2_drv_i(k2), .bus_i(bin),
    .bus_o(bout), .bus_oe_o(oe), .rc_val_o(rcv),
    .cond_o(con), .shamt_o(n)
  );

  typedef struct {
    logic [31:0] bus;
    logic        oe;
    logic [31:0] rc;
    logic        con;
    logic [4:0]  n;
    string       tag;
  } exp_t;

  exp_t        sbq[$];
  logic [31:0] mreg [32];
  int          checks = 0, errors = 0;
  bit          done = 0;

  function automatic logic [31:0] mk_ir(int ra, int rb, int rc, logic [11:0] lo);
    return {5'd0, 5'(ra), 5'(rb), 5'(rc), lo};
  endfunction

  function automatic logic [31:0] pat(int i);
    if (i == 0) return 32'hA5A5_0001;
    if (i == 5) return 32'h0;
    return (32'(i) * 32'h0DEF_1357) ^ ((i % 2) ? 32'h8000_0000 : 32'h0);
  endfunction

  // driver: apply stimulus just after the falling edge and queue expectations
  task automatic step(input logic [31:0] i_ir, input logic a, b, c,
                      input logic w, r, bsel, q1, q2, input logic [31:0] d,
                      input string tag);
    exp_t e;
    int   idx;
    bit   hit;
    @(negedge clk);
    ir = i_ir; sa = a; sb = b; sc = c; we = w; rd = r; ba = bsel;
    k1 = q1; k2 = q2; bin = d;
    hit = a | b | c;
    idx = a ? int'(i_ir[26:22]) : b ? int'(i_ir[21:17]) : int'(i_ir[16:12]);
    e.tag = tag;
    e.rc  = mreg[i_ir[16:12]];
    e.oe  = r | bsel | q1 | q2;
    if (r)         e.bus = hit ? mreg[idx] : 32'h0;
    else if (bsel) e.bus = (hit && idx != 0) ? mreg[idx] : 32'h0;
    else if (q1)   e.bus = {{10{i_ir[21]}}, i_ir[21:0]};
    else if (q2)   e.bus = {{15{i_ir[16]}}, i_ir[16:0]};
    else           e.bus = 32'h0;
    case (i_ir[2:0])
      3'd1: e.con = 1'b1;
      3'd2: e.con = (e.rc == 0);
      3'd3: e.con = (e.rc != 0);
      3'd4: e.con = ~e.rc[31];
      3'd5: e.con = e.rc[31];
      default: e.con = 1'b0;
    endcase
    e.n = (i_ir[4:0] != 0) ? i_ir[4:0] : e.rc[4:0];
    sbq.push_back(e);
    if (w && hit) mreg[idx] = d;  // visible after the coming rising edge
  endtask

  // monitor: sample 1 ns after the falling edge, before the write edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (bout !== e.bus || oe !== e.oe || rcv !== e.rc || con !== e.con || n !== e.n) begin
          errors++;
          $display("FAIL %s: bus=%h oe=%b rc=%h con=%b n=%0d expected bus=%h oe=%b rc=%h con=%b n=%0d",
                   e.tag, bout, oe, rcv, con, n, e.bus, e.oe, e.rc, e.con, e.n);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: reset state seen through the rc port and a plain read
    for (int i = 0; i < 32; i += 7)
      step(mk_ir(i, 0, i, 12'h0), 1, 0, 0, 0, 1, 0, 0, 0, 32'h0, "R1 reset zero");
    // R2 / R10: fill every register through the ra field, r0 included
    for (int i = 0; i < 32; i++)
      step(mk_ir(i, 31 - i, 3, 12'h0), 1, 0, 0, 1, 0, 0, 0, 0, pat(i), "R2 write ra");
    // R3 / R10: read back through rb and rc fields
    for (int i = 0; i < 32; i++)
      step(mk_ir(7, i, 9, 12'h0), 0, 1, 0, 0, 1, 0, 0, 0, 32'h0, "R3 R10 read rb");
    step(mk_ir(0, 0, 0, 12'h0), 0, 0, 1, 0, 1, 0, 0, 0, 32'h0, "R10 r0 plain read");
    step(mk_ir(1, 2, 3, 12'h0), 0, 0, 0, 0, 1, 0, 0, 0, 32'h0, "R3 no grant");
    // R2 priority: ra over rb, rb over rc, no grant no write
    step(mk_ir(10, 11, 12, 12'h0), 1, 1, 1, 1, 0, 0, 0, 0, 32'h1111_2222, "R2 prio a");
    step(mk_ir(10, 11, 12, 12'h0), 0, 1, 1, 1, 0, 0, 0, 0, 32'h3333_4444, "R2 prio b");
    step(mk_ir(10, 11, 12, 12'h0), 0, 0, 1, 1, 0, 0, 0, 0, 32'h5555_6666, "R2 write c");
    step(mk_ir(10, 11, 12, 12'h0), 0, 0, 0, 1, 0, 0, 0, 0, 32'hDEAD_BEEF, "R2 no grant");
    step(mk_ir(10, 11, 12, 12'h0), 1, 0, 0, 0, 1, 0, 0, 0, 32'h0, "R2 check ra");
    step(mk_ir(10, 11, 12, 12'h0), 0, 1, 0, 0, 1, 0, 0, 0, 32'h0, "R2 check rb");
    // R4 base-address path
    step(mk_ir(0, 0, 4, 12'h0), 1, 0, 0, 0, 0, 1, 0, 0, 32'h0, "R4 base r0 zero");
    step(mk_ir(3, 0, 4, 12'h0), 0, 1, 0, 0, 0, 1, 0, 0, 32'h0, "R4 base rb r0");
    step(mk_ir(3, 9, 4, 12'h0), 0, 1, 0, 0, 0, 1, 0, 0, 32'h0, "R4 base r9");
    // R5 rc port independent of grants
    step(mk_ir(1, 2, 6, 12'h0), 1, 1, 1, 0, 0, 0, 0, 0, 32'h0, "R5 rc with grants");
    step(mk_ir(1, 2, 0, 12'h0), 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, "R5 rc r0");
    // R6 condition codes against zero (r5), negative (r1), positive (r2)
    for (int cc = 0; cc < 8; cc++) begin
      step(mk_ir(0, 0, 5, 12'(cc)), 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, "R6 cc zero reg");
      step(mk_ir(0, 0, 1, 12'(cc)), 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, "R6 cc neg reg");
      step(mk_ir(0, 0, 2, 12'(cc)), 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, "R6 cc pos reg");
    end
    // R7 shift count: immediate, and register when immediate is zero
    step(mk_ir(0, 0, 3, 12'h01F), 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, "R7 imm 31");
    step(mk_ir(0, 0, 3, 12'h001), 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, "R7 imm 1");
    step(mk_ir(0, 0, 3, 12'hFE0), 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, "R7 reg count");
    step(mk_ir(0, 0, 7, 12'h000), 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, "R7 reg count r7");
    // R8 constants, both signs
    step(32'h0020_0123, 0, 0, 0, 0, 0, 0, 1, 0, 32'h0, "R8 c1 negative");
    step(32'h001F_F000, 0, 0, 0, 0, 0, 0, 1, 0, 32'h0, "R8 c1 positive");
    step(32'h0001_0005, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0, "R8 c2 negative");
    step(32'h0002_FFFF, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0, "R8 c2 positive");
    // R9 idle bus
    step(mk_ir(4, 4, 4, 12'h0), 1, 1, 1, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, "R9 idle bus");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule